// File: doc/BRIEF.md
# Output-Port Weighted Round-Robin Crosspoint Scheduler

This block sits at one output port of a buffered crossbar and decides which crosspoint buffer in that output's column drives the output next. It looks only at the per-crosspoint data-available flags of its own column. It acts without any coordination with other outputs or with the input-side logic. Each decision is registered and shown as a one-hot grant vector with a matching binary index and a valid flag.

Grants cover whole packets. Once a crosspoint is granted, the grant stays until that crosspoint signals end of packet. The packets can have any length. Fairness follows a weighted round-robin. Each input has a weight, which is the number of back-to-back packets it may send in one turn. When a turn ends, the search for the next winner starts at the index just after the crosspoint that last held the grant. The scheduler hands the grant over on the edge that registers the end-of-packet, so a waiting crosspoint gets the output with no empty cycle in between.

Top module: `wrr_out_sched`

## Requirements
- R1: After reset the grant vector is all zeros, the valid output is 0, the index output is 0, and the first search starts at index 0.
- R2: A grant is issued only to a crosspoint whose available flag was 1 at the deciding clock edge. When every flag is 0, no grant is issued.
- R3: While a grant is held and end-of-packet is 0, the grant and index stay unchanged, whatever the available flags do.
- R4: When end-of-packet is 1 while a grant is held and any crosspoint is eligible, the output is granted again on the next cycle, with no cycle where valid is 0.
- R5: When a turn ends, the new winner is the first eligible crosspoint found when scanning upward from the index after the last holder, wrapping from N-1 to 0.
- R6: A turn lasts at most `weight` consecutive packets, where the weight of input k is bits [k*WB +: WB] of the weight port. A weight of 0 allows one packet.
- R7: The packet count is reloaded whenever a turn starts. This includes a new turn for the same crosspoint after the scan wraps back to it.
- R8: If the holder's available flag is 0 at its end-of-packet, its turn ends early and it is not granted on the next cycle.
- R9: When nothing is eligible, valid drops to 0 and the search position is kept for the next grant. End-of-packet is ignored while no grant is held.
- R10: A decision appears on the outputs one clock edge after the inputs that caused it. The grant vector then has exactly bit `index` set when valid is 1, and is all zeros when valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avail_i | input | N_IN | Data-available flag per crosspoint in this column |
| eop_i | input | 1 | End of packet from the currently granted crosspoint |
| weights_i | input | N_IN*WB | Packets-per-turn weight for each input, WB bits each |
| grant_o | output | N_IN | One-hot grant to the chosen crosspoint |
| sel_o | output | IW | Binary index of the granted crosspoint |
| valid_o | output | 1 | A grant is currently held |

## Verification
Every result is due exactly one rising edge after the available flags and end-of-packet value that produced it. This applies to a fresh grant, a handover after end-of-packet, a continued turn, and a drop to idle. The driver changes inputs on a falling edge and queues the grant it expects for the next rising edge. The monitor pops that entry one time unit after the rising edge and compares valid, index and the full grant vector. Only one expectation is ever in flight, so each check lines up with the single register stage.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

    // Kind of decision taken at a clock edge.
    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,   // packet in progress, keep grant
        DEC_CONT = 2'd1,   // same holder, next packet of its turn
        DEC_NEW  = 2'd2,   // new turn starts
        DEC_IDLE = 2'd3    // nothing eligible
    } dec_e;

endpackage

// File: rtl/wrr_rr_pick.sv
module wrr_rr_pick #(
    parameter int N_IN = 4,
    parameter int IW   = 2
) (
    input  logic [N_IN-1:0] req_i,
    input  logic [IW-1:0]   start_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);

    // Rotating-priority search: lowest offset from start_i wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < N_IN; k++) begin
            int p;
            p = int'(start_i) + k;
            if (p >= N_IN) p = p - N_IN;
            if (!found_o && req_i[p]) begin
                found_o = 1'b1;
                idx_o   = IW'(p);
            end
        end
    end

endmodule

// File: rtl/wrr_weight_mux.sv
module wrr_weight_mux #(
    parameter int N_IN = 4,
    parameter int WB   = 4,
    parameter int IW   = 2
) (
    input  logic [N_IN*WB-1:0] weights_i,
    input  logic [IW-1:0]      idx_i,
    output logic [WB-1:0]      wt_o
);

    logic [WB-1:0] tbl [N_IN];

    for (genvar g = 0; g < N_IN; g++) begin : g_unpack
        assign tbl[g] = weights_i[g*WB +: WB];
    end

    assign wt_o = tbl[idx_i];

endmodule

// File: rtl/wrr_out_sched.sv
module wrr_out_sched
    import wrr_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int WB   = 4,
    parameter int IW   = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IN-1:0]    avail_i,
    input  logic               eop_i,
    input  logic [N_IN*WB-1:0] weights_i,
    output logic [N_IN-1:0]    grant_o,
    output logic [IW-1:0]      sel_o,
    output logic               valid_o
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N_IN - 1);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] sel;
        logic [IW-1:0] ptr;
        logic [WB-1:0] cnt;   // packets left in the turn after the current one
    } st_t;

    st_t           st_q, st_d;
    dec_e          dec;
    logic [IW-1:0] after_sel;
    logic [IW-1:0] start;
    logic          pick_found;
    logic [IW-1:0] pick_idx;
    logic [WB-1:0] pick_wt;

    // Position after the current holder, with wrap.
    always_comb begin
        after_sel = (st_q.sel == LAST_IDX) ? '0 : st_q.sel + 1'b1;
        start     = st_q.busy ? after_sel : st_q.ptr;
    end

    wrr_rr_pick #(.N_IN(N_IN), .IW(IW)) u_pick (
        .req_i   (avail_i),
        .start_i (start),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    wrr_weight_mux #(.N_IN(N_IN), .WB(WB), .IW(IW)) u_wmux (
        .weights_i (weights_i),
        .idx_i     (pick_idx),
        .wt_o      (pick_wt)
    );

    // Decision and next state.
    always_comb begin
        if (st_q.busy && !eop_i)
            dec = DEC_HOLD;
        else if (st_q.busy && eop_i && (st_q.cnt != '0) && avail_i[st_q.sel])
            dec = DEC_CONT;
        else if (pick_found)
            dec = DEC_NEW;
        else
            dec = DEC_IDLE;

        st_d = st_q;
        unique case (dec)
            DEC_HOLD: st_d = st_q;
            DEC_CONT: st_d.cnt = st_q.cnt - 1'b1;
            DEC_NEW: begin
                st_d.busy = 1'b1;
                st_d.sel  = pick_idx;
                st_d.ptr  = start;
                st_d.cnt  = (pick_wt == '0) ? '0 : pick_wt - 1'b1;
            end
            DEC_IDLE: begin
                st_d.busy = 1'b0;
                st_d.ptr  = start;
                st_d.cnt  = '0;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        grant_o = '0;
        if (st_q.busy) grant_o[st_q.sel] = 1'b1;
    end

    assign sel_o   = st_q.sel;
    assign valid_o = st_q.busy;

    // R3: a packet in flight keeps its grant.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !eop_i) |=> (valid_o && $stable(sel_o)));

    // R2: a grant that starts from idle goes to a crosspoint that was available.
    a_r2_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o) |=> (!valid_o || (|($past(avail_i) & grant_o))));

    // R9: no eligible crosspoint while idle keeps the output idle.
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && (avail_i == '0)) |=> !valid_o);

    // R4: end of packet with any eligible crosspoint leaves no gap.
    a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && eop_i && (avail_i != '0)) |=> valid_o);

    // R8: a holder that is no longer available loses the grant at its end of packet.
    a_r8_turn_end: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && eop_i && ((avail_i & grant_o) == '0)) |=>
            (!valid_o || (sel_o != $past(sel_o))));

endmodule

// File: tb/sim_wrr_out_sched.sv
`timescale 1ns/1ps
module sim_wrr_out_sched;

    localparam int N_IN = 4;
    localparam int WB   = 4;
    localparam int IW   = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N_IN-1:0]    avail = '0;
    logic               eop = 1'b0;
    logic [N_IN*WB-1:0] weights;
    logic [N_IN-1:0]    grant;
    logic [IW-1:0]      sel;
    logic               valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  v;
        int    s;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    // weights: idx0=2, idx1=1, idx2=0, idx3=3
    assign weights = {4'd3, 4'd0, 4'd1, 4'd2};

    wrr_out_sched #(.N_IN(N_IN), .WB(WB), .IW(IW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .avail_i   (avail),
        .eop_i     (eop),
        .weights_i (weights),
        .grant_o   (grant),
        .sel_o     (sel),
        .valid_o   (valid)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        logic [N_IN-1:0] eg;
        eg = e.v ? (N_IN'(1) << e.s) : '0;
        check(e.tag, "valid", int'(valid), int'(e.v));
        check(e.tag, "grant", int'(grant), int'(eg));
        if (e.v) check(e.tag, "sel", int'(sel), e.s);
    endtask

    // Driver: apply inputs on the falling edge, queue the result due after the next rising edge.
    task automatic step(input logic [N_IN-1:0] av, input logic e,
                        input logic ev, input int es, input string tag);
        exp_t it;
        @(negedge clk);
        avail = av;
        eop   = e;
        it.v = ev; it.s = es; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front());
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "valid", int'(valid), 0);
        check("R1", "grant", int'(grant), 0);
        check("R1", "sel", int'(sel), 0);

        step(4'b0000, 1'b0, 1'b0, 0, "R2");      // nothing eligible
        step(4'b1010, 1'b0, 1'b1, 1, "R10");     // scan from 0 -> idx1, one edge later
        step(4'b0000, 1'b0, 1'b1, 1, "R3");      // flags drop, grant held
        step(4'b1010, 1'b1, 1'b1, 3, "R4");      // weight 1 used, hand to idx3
        step(4'b1010, 1'b1, 1'b1, 3, "R6");      // idx3 packet 2
        step(4'b1010, 1'b1, 1'b1, 3, "R6");      // idx3 packet 3
        step(4'b1010, 1'b1, 1'b1, 1, "R5");      // turn over, wrap to idx1
        step(4'b0000, 1'b1, 1'b0, 0, "R9");      // idle, position 2 kept
        step(4'b0000, 1'b1, 1'b0, 0, "R9");      // eop while idle ignored
        step(4'b0011, 1'b0, 1'b1, 0, "R5");      // scan from 2 -> idx0
        step(4'b0010, 1'b1, 1'b1, 1, "R8");      // idx0 not available, turn ends
        step(4'b0101, 1'b1, 1'b1, 2, "R5");      // scan from 2 -> idx2
        step(4'b0101, 1'b1, 1'b1, 0, "R6");      // weight 0 gives one packet
        step(4'b0001, 1'b0, 1'b1, 0, "R3");      // hold
        step(4'b0001, 1'b1, 1'b1, 0, "R6");      // idx0 second packet
        step(4'b0001, 1'b1, 1'b1, 0, "R7");      // wraps back to idx0, reload
        step(4'b0001, 1'b1, 1'b1, 0, "R7");      // reloaded turn, second packet
        step(4'b0000, 1'b1, 1'b0, 0, "R9");      // idle
        step(4'b0100, 1'b0, 1'b1, 2, "R2");      // scan from 1 -> idx2

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule